// File: doc/BRIEF.md
# Double-Buffered Octal Converter Code Register Bank

This block is the synchronous digital front end of an eight-channel, 14-bit voltage-output converter. A host drives a parallel data bus, a channel address and four active-low strobes (select, write, load, clear). Each channel keeps two registers. The first is an input register, chosen by the address. The second is an output register, and all eight are loaded together by the load strobe. The block presents the code each channel would convert, and a per-channel flag that asks the analog side to drive that channel to its ground level.

The strobes act as level-sensitive enables, in the way transparent latches would. They are sampled on the system clock through two flip-flops. The bus and the address travel in the same two-stage pipeline, so they stay aligned with the strobes. While an enable condition holds, the selected register reloads on every clock.

A clear hides every output behind the mid-scale code and raises all ground flags. The contents of both register stages are kept. When clear is released, each channel shows its output register again.

Top module: `dac_regbank`

## Requirements
- R1: The address picks the channel in binary order. Address value k selects channel k, whose code is `code_o[k*14 +: 14]`, so 3'b000 is the lowest slice and 3'b111 the highest.
- R2: The addressed input register loads the bus on every clock while `cs_n_i` and `wr_n_i` are both 0. It holds whenever either of them is 1, and other channels are never written.
- R3: While `ld_n_i` is 0, all eight output registers copy their input registers on every clock. While it is 1, they hold, so one load updates every channel together.
- R4: With `cs_n_i`, `wr_n_i` and `ld_n_i` all 0, each new bus value reaches the addressed channel's `code_o` slice with no extra load step.
- R5: While `clr_n_i` is 0, every `code_o` slice reads mid-scale 14'h2000 and every bit of `zero_o` is 1. Writes and loads still act on the registers during a clear.
- R6: After `clr_n_i` returns to 1, each channel shows its output register contents, including any load made during the clear, and `zero_o` returns to all zeros.
- R7: Codes are offset binary and pass unchanged across the full range: 14'h0000 (most negative), 14'h2000 (zero) and 14'h3FFF (full scale minus one LSB).
- R8: An input pattern present at the ports before clock edge n shows at `code_o` and `zero_o` just after edge n+2. Two edges go to the synchronizer and one to the register stages.
- R9: A synchronous active-high `rst` sets every input and output register to 14'h2000 and clears `zero_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 14 | Parallel code bus, offset binary |
| addr_i | input | 3 | Channel address |
| cs_n_i | input | 1 | Select strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ld_n_i | input | 1 | Transfer strobe for all channels, active low |
| clr_n_i | input | 1 | Clear-to-ground strobe, active low |
| code_o | output | 112 | Effective codes of channels 0..7, 14 bits each, channel 0 in the low bits |
| zero_o | output | 8 | Per-channel drive-to-ground flags |

## Verification
A write and a load can fall in the same clock. When both enables hold, the written value must pass through to the output register within that same update. The bench provokes this with vectors that hold select, write and load low together, changes the bus under them, and expects the addressed slice to track the bus while every other channel picks up its stored input. Write and load are also issued during a clear. The result is judged only after release, through the restored codes, and each comparison is made against a bench model of both register stages.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  // mid-scale of an offset-binary code of width w
  function automatic logic [31:0] mid_code(input int w);
    return 32'(1) << (w - 1);
  endfunction
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
  parameter int NCH = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_act_i,
  output logic [NCH-1:0] wr_en_o
);
  always_comb begin
    wr_en_o = '0;
    for (int k = 0; k < NCH; k++)
      if (wr_act_i && (addr_i == AW'(k))) wr_en_o[k] = 1'b1;
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic          ld_en_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] code_o,
  output logic          zero_o
);
  localparam logic [DW-1:0] MID = DW'(mid_code(DW));

  logic [DW-1:0] in_q, out_q, code_q;
  logic [DW-1:0] in_nxt, out_nxt;
  logic          zero_q;

  // transparent chain: a write seen in the same cycle as a load reaches out_q
  assign in_nxt  = wr_en_i ? data_i : in_q;
  assign out_nxt = ld_en_i ? in_nxt : out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q   <= MID;
      out_q  <= MID;
      code_q <= MID;
      zero_q <= 1'b0;
    end else begin
      in_q   <= in_nxt;
      out_q  <= out_nxt;
      code_q <= clr_i ? MID : out_nxt;
      zero_q <= clr_i;
    end
  end

  assign code_o = code_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank #(
  parameter int NCH = 8,
  parameter int DW  = 14,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     data_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              cs_n_i,
  input  logic              wr_n_i,
  input  logic              ld_n_i,
  input  logic              clr_n_i,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0]    zero_o
);
  localparam int SW = 4 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {(AW + DW){1'b0}}};

  logic [SW-1:0]  raw, synced;
  logic           cs_n_s, wr_n_s, ld_n_s, clr_n_s;
  logic [AW-1:0]  addr_s;
  logic [DW-1:0]  data_s;
  logic [NCH-1:0] wr_en;

  assign raw = {clr_n_i, ld_n_i, wr_n_i, cs_n_i, addr_i, data_i};

  dacbank_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
  );

  assign {clr_n_s, ld_n_s, wr_n_s, cs_n_s, addr_s, data_s} = synced;

  dacbank_decode #(.NCH(NCH)) u_dec (
    .addr_i(addr_s), .wr_act_i(!cs_n_s && !wr_n_s), .wr_en_o(wr_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacbank_chan #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .wr_en_i(wr_en[g]),
      .ld_en_i(!ld_n_s),
      .clr_i  (!clr_n_s),
      .data_i (data_s),
      .code_o (code_o[g*DW +: DW]),
      .zero_o (zero_o[g])
    );
  end
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
  import dacbank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 14,
  parameter int AW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_n_i,
  input logic              clr_n_i,
  input logic [NCH*DW-1:0] code_o,
  input logic [NCH-1:0]    zero_o
);
  localparam logic [DW-1:0] MID = DW'(mid_code(DW));
  localparam logic [NCH*DW-1:0] ALL_MID = {NCH{MID}};

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd6) since_rst <= since_rst + 3'd1;
  end

  // R9: first cycle after reset shows mid-scale everywhere and no ground flag
  a_r9_reset_mid: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_o == ALL_MID && zero_o == '0));

  // R5: ground flags are all set or all clear
  a_r5_flags_uniform: assert property (@(posedge clk) disable iff (rst)
    ($countones(zero_o) == 0) || ($countones(zero_o) == NCH));

  // R5: a flagged channel shows mid-scale
  for (genvar g = 0; g < NCH; g++) begin : g_clr
    a_r5_clear_mid: assert property (@(posedge clk) disable iff (rst)
      zero_o[g] |-> (code_o[g*DW +: DW] == MID));
  end

  // R8: the flags follow the clear strobe three edges later
  a_r8_clear_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd6) |-> (zero_o == {NCH{!$past(clr_n_i, 3)}}));

  // R3: without a load and outside a clear transition the codes hold
  a_r3_hold_no_load: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd6 && $past(ld_n_i, 3) && $past(clr_n_i, 3) && $past(clr_n_i, 4))
      |-> $stable(code_o));
endmodule

bind dac_regbank dac_regbank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ld_n_i(ld_n_i), .clr_n_i(clr_n_i),
  .code_o(code_o), .zero_o(zero_o)
);

// File: tb/sim_dac_regbank.sv
module sim_dac_regbank;
  localparam int NCH = 8;
  localparam int DW  = 14;
  localparam int AW  = 3;
  localparam logic [DW-1:0] MID = 14'h2000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DW-1:0]     data_i = '0;
  logic [AW-1:0]     addr_i = '0;
  logic              cs_n_i = 1'b1, wr_n_i = 1'b1, ld_n_i = 1'b1, clr_n_i = 1'b1;
  logic [NCH*DW-1:0] code_o;
  logic [NCH-1:0]    zero_o;

  always #5 clk = ~clk;

  dac_regbank #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .data_i(data_i), .addr_i(addr_i),
    .cs_n_i(cs_n_i), .wr_n_i(wr_n_i), .ld_n_i(ld_n_i), .clr_n_i(clr_n_i),
    .code_o(code_o), .zero_o(zero_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model of both register stages
  logic [DW-1:0] m_in  [NCH];
  logic [DW-1:0] m_out [NCH];
  logic          m_clr;

  task automatic check(input string req, input logic [NCH*DW-1:0] act,
                       input logic [NCH*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*DW-1:0] model_bus();
    logic [NCH*DW-1:0] b;
    for (int k = 0; k < NCH; k++) b[k*DW +: DW] = m_clr ? MID : m_out[k];
    return b;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NCH; k++) begin m_in[k] = MID; m_out[k] = MID; end
    m_clr = 1'b0;
  endtask

  // drive a pattern, hold it four cycles, update model
  task automatic apply(input logic clr_n, ld_n, wr_n, cs_n,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    clr_n_i = clr_n; ld_n_i = ld_n; wr_n_i = wr_n; cs_n_i = cs_n;
    addr_i = a; data_i = d;
    if (!cs_n && !wr_n) m_in[a] = d;
    if (!ld_n) for (int k = 0; k < NCH; k++) m_out[k] = m_in[k];
    m_clr = !clr_n;
    repeat (4) @(negedge clk);
  endtask

  // {clr_n, ld_n, wr_n, cs_n, addr, data, expected code of addressed channel, expected flag}
  localparam int NV = 15;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b0,3'd0,14'h0123,14'h2000,1'b0}, // R2 write ch0, no load
    {1'b1,1'b1,1'b0,1'b0,3'd7,14'h3FFF,14'h2000,1'b0}, // R2 R7 write ch7 full scale
    {1'b1,1'b1,1'b1,1'b0,3'd3,14'h1111,14'h2000,1'b0}, // R2 write strobe high
    {1'b1,1'b1,1'b0,1'b1,3'd3,14'h1111,14'h2000,1'b0}, // R2 select high
    {1'b1,1'b0,1'b1,1'b1,3'd0,14'h0000,14'h0123,1'b0}, // R3 load all
    {1'b1,1'b0,1'b1,1'b1,3'd7,14'h0000,14'h3FFF,1'b0}, // R3 R7 same load seen on ch7
    {1'b0,1'b1,1'b1,1'b1,3'd0,14'h0000,14'h2000,1'b1}, // R5 clear
    {1'b0,1'b1,1'b0,1'b0,3'd0,14'h0AAA,14'h2000,1'b1}, // R5 write during clear
    {1'b1,1'b1,1'b1,1'b1,3'd0,14'h0000,14'h0123,1'b0}, // R6 release keeps out reg
    {1'b1,1'b0,1'b0,1'b0,3'd2,14'h3000,14'h3000,1'b0}, // R4 pass-through
    {1'b1,1'b0,1'b0,1'b0,3'd2,14'h0001,14'h0001,1'b0}, // R4 bus change follows
    {1'b1,1'b1,1'b1,1'b1,3'd0,14'h0000,14'h0AAA,1'b0}, // R3 ch0 got value written in clear
    {1'b1,1'b1,1'b0,1'b0,3'd5,14'h0000,14'h2000,1'b0}, // R7 write zero code ch5
    {1'b0,1'b0,1'b1,1'b1,3'd5,14'h0000,14'h2000,1'b1}, // R5 load during clear hidden
    {1'b1,1'b1,1'b1,1'b1,3'd5,14'h0000,14'h0000,1'b0}  // R6 R7 load shows after release
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 reset codes", code_o, {NCH{MID}});
    check("R9 reset flags", {{(NCH*DW-NCH){1'b0}}, zero_o}, '0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      apply(VEC[v][35], VEC[v][34], VEC[v][33], VEC[v][32], VEC[v][31:29], VEC[v][28:15]);
      a = VEC[v][31:29];
      check($sformatf("R2/R3/R4/R5/R6 vector %0d channel", v),
            {{(NCH*DW-DW){1'b0}}, code_o[a*DW +: DW]},
            {{(NCH*DW-DW){1'b0}}, VEC[v][14:1]});
      check($sformatf("R5 vector %0d flag", v),
            {{(NCH*DW-1){1'b0}}, zero_o[a]}, {{(NCH*DW-1){1'b0}}, VEC[v][0]});
      check($sformatf("R3 vector %0d full bus", v), code_o, model_bus());
    end

    // R1: address order, distinct value per channel
    for (int k = 0; k < NCH; k++)
      apply(1'b1, 1'b1, 1'b0, 1'b0, AW'(k), DW'(14'h0100 * k + k + 14'h0040));
    apply(1'b1, 1'b0, 1'b1, 1'b1, '0, '0);
    apply(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    for (int k = 0; k < NCH; k++)
      check($sformatf("R1 channel %0d slice", k),
            {{(NCH*DW-DW){1'b0}}, code_o[k*DW +: DW]},
            {{(NCH*DW-DW){1'b0}}, DW'(14'h0100 * k + k + 14'h0040)});

    // R8: latency of a combined write and load on channel 1
    @(negedge clk);
    cs_n_i = 1'b0; wr_n_i = 1'b0; ld_n_i = 1'b0; addr_i = 3'd1; data_i = 14'h1234;
    m_in[1] = 14'h1234;
    for (int k = 0; k < NCH; k++) m_out[k] = m_in[k];
    @(posedge clk); @(posedge clk); #2;
    check("R8 old value after two edges",
          {{(NCH*DW-DW){1'b0}}, code_o[1*DW +: DW]},
          {{(NCH*DW-DW){1'b0}}, 14'h0141});
    @(posedge clk); #2;
    check("R8 new value after third edge",
          {{(NCH*DW-DW){1'b0}}, code_o[1*DW +: DW]},
          {{(NCH*DW-DW){1'b0}}, 14'h1234});
    apply(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    check("R3 full bus after latency test", code_o, model_bus());

    // R9: reset in mid-run restores mid-scale
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    model_reset();
    check("R9 mid-run reset codes", code_o, {NCH{MID}});
    apply(1'b1, 1'b0, 1'b1, 1'b1, '0, '0);
    check("R9 load after reset gives mid-scale", code_o, model_bus());

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule